// File: doc/BRIEF.md
# Bias Calibration Sequencer

This block runs a one-time calibration at power-up that finds a fixed bias trim code. After an accepted start request it powers up the helper reference circuit and the comparator. It then waits until the reference reports that it has settled. From that point it walks a 3-bit trim code upward from zero, one step at a time. After each step it waits a fixed settle interval and then samples the comparator, which tells it whether the trimmed level now lies above the process-dependent reference.

The search ends in one of two ways. It ends when the comparator trips, or when the code reaches its top value without a trip, which also raises a saturation flag. When the search ends, the block switches off the reference and the comparator and freezes the code. It stays finished until the next reset.

The comparator output comes from analog circuitry and is therefore treated as asynchronous. The settled flag of the reference is taken to be synchronous to the clock. Every pin is a plain level or pulse. The block has no streaming interface and no back-pressure.

Top module: `bias_cal_seq`

## Requirements
- R1: While reset is asserted and directly after it, trim_code is 3'b000 and busy, done, sat, ref_en and cmp_en are all 0.
- R2: A one-cycle start pulse in the idle state is accepted: on the next cycle busy, ref_en and cmp_en are 1, done is 0 and trim_code is 3'b000.
- R3: While ref_ready is low after an accepted start, trim_code stays at 3'b000 and done stays 0, whatever the comparator reports.
- R4: Each comparator sample comes at least SETTLE_CYC cycles after the previous code change, or after ref_ready was seen high. Consecutive code changes are therefore at least SETTLE_CYC cycles apart.
- R5: The comparator input goes through a two-flop synchronizer before it is used. During a run, trim_code only ever changes by +1.
- R6: When the synchronized comparator reads 1 at a sample, the run ends with trim_code equal to the lowest code at which the comparator reads 1, and sat is 0.
- R7: When trim_code reaches 3'b111 and the comparator still reads 0 at the sample, the run ends with trim_code = 3'b111 and sat = 1.
- R8: While done is 1, ref_en, cmp_en and busy are 0, and trim_code does not change.
- R9: Start pulses are ignored while busy is 1 and after done is 1. Only a reset lets a new run begin.
- R10: busy and done are never 1 in the same cycle, and done stays 1 once it has risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin calibration |
| ref_ready_i | input | 1 | Reference has started and settled (synchronous) |
| cmp_above_i | input | 1 | Comparator: trimmed level above reference (asynchronous) |
| trim_code_o | output | 3 | Current trim code driving the weighted current sources |
| ref_en_o | output | 1 | Enable for the helper reference generator |
| cmp_en_o | output | 1 | Enable for the comparator |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | Calibration finished; code frozen |
| sat_o | output | 1 | Search hit the top code without a comparator trip |

## Verification
The assertions check on every cycle the invariants that hold in any run. They cover the exclusive busy/done pairing, the sticky done state, the code held still while done is 1, enables off at the end, the single-step code changes, the code pinned at zero before the reference is ready, and the bound on the settle timer. Only the bench's scenarios can show the outcome of a search: that the final code is the first one where the comparator trips, that saturation happens at the top code, that the settle spacing holds between steps, and that start pulses during and after a run really leave the code unchanged.

// File: rtl/bcal_pkg.sv
package bcal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_REF,
    ST_SETTLE,
    ST_SAMPLE,
    ST_DONE
  } bcal_state_e;
endpackage

// File: rtl/bcal_sync.sv
module bcal_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bcal_settle_timer.sv
module bcal_settle_timer #(
  parameter int CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R4
  AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/bcal_trim_counter.sv
module bcal_trim_counter #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] code_o,
  output logic         at_max_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     code_q <= '0;
    else if (clr_i)                 code_q <= '0;
    else if (inc_i && code_q != TOP) code_q <= code_q + 1'b1;
  end

  assign code_o   = code_q;
  assign at_max_o = (code_q == TOP);

  AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && (code_q != $past(code_q))) |-> (code_q == $past(code_q) + 1'b1)); // R5
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max_o && !clr_i) |=> at_max_o); // R7
endmodule

// File: rtl/bias_cal_seq.sv
module bias_cal_seq #(
  parameter int CODE_W      = 3,
  parameter int SETTLE_CYC  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              ref_ready_i,
  input  logic              cmp_above_i,
  output logic [CODE_W-1:0] trim_code_o,
  output logic              ref_en_o,
  output logic              cmp_en_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              sat_o
);
  import bcal_pkg::*;

  bcal_state_e state_q, state_d;
  logic cmp_sync, tmr_expired, at_max;
  logic code_clr, code_inc, sat_q;
  logic [CODE_W-1:0] code;

  bcal_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(cmp_above_i), .q_o(cmp_sync)
  );

  bcal_settle_timer #(.CYCLES(SETTLE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(state_q == ST_SETTLE), .expired_o(tmr_expired)
  );

  bcal_trim_counter #(.W(CODE_W)) u_code (
    .clk(clk), .rst_n(rst_n), .clr_i(code_clr), .inc_i(code_inc),
    .code_o(code), .at_max_o(at_max)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start_i)     state_d = ST_WAIT_REF;
      ST_WAIT_REF: if (ref_ready_i) state_d = ST_SETTLE;
      ST_SETTLE:   if (tmr_expired) state_d = ST_SAMPLE;
      ST_SAMPLE:   state_d = (cmp_sync || at_max) ? ST_DONE : ST_SETTLE;
      ST_DONE:     state_d = ST_DONE;
      default:     state_d = ST_IDLE;
    endcase
  end

  assign code_clr = (state_q == ST_IDLE) && start_i;
  assign code_inc = (state_q == ST_SAMPLE) && !cmp_sync && !at_max;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sat_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_SAMPLE && !cmp_sync && at_max) sat_q <= 1'b1;
    end
  end

  assign busy_o      = (state_q == ST_WAIT_REF) || (state_q == ST_SETTLE) || (state_q == ST_SAMPLE);
  assign ref_en_o    = busy_o;
  assign cmp_en_o    = busy_o;
  assign done_o      = (state_q == ST_DONE);
  assign sat_o       = sat_q;
  assign trim_code_o = code;

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o)); // R10
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o); // R10
  AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(done_o)) |-> $stable(trim_code_o)); // R8
  AST_HELPERS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!ref_en_o && !cmp_en_o)); // R8
  AST_ZERO_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_REF) |-> (trim_code_o == '0)); // R3
  AST_SAT_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    sat_o |-> (trim_code_o == {CODE_W{1'b1}})); // R7
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_i) |=> (busy_o && trim_code_o == '0)); // R2
endmodule

// File: tb/bias_cal_seq_test.sv
module bias_cal_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ready = 1'b0;
  logic cmp;
  logic [2:0] code;
  logic ref_en, cmp_en, busy, done, sat;
  int thr = 100;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int last_chg = 0;
  int gap_viol = 0;
  int step_viol = 0;
  logic [2:0] prev_code = 3'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cmp = (int'(code) > thr);

  bias_cal_seq #(.CODE_W(3), .SETTLE_CYC(SETTLE), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ref_ready_i(ready),
    .cmp_above_i(cmp), .trim_code_o(code), .ref_en_o(ref_en), .cmp_en_o(cmp_en),
    .busy_o(busy), .done_o(done), .sat_o(sat)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && busy && code != prev_code) begin
      if (code != prev_code + 3'd1) step_viol <= step_viol + 1;
      if (last_chg != 0 && (cyc - last_chg) < SETTLE) gap_viol <= gap_viol + 1;
      last_chg <= cyc;
    end
    prev_code <= code;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; ready = 1'b0;
    repeat (3) @(negedge clk);
    check(code == 0 && !busy && !done && !sat && !ref_en && !cmp_en, "R1 reset", {code, busy, done, sat}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(code == 0 && !busy && !done && !sat && !ref_en && !cmp_en, "R1 after reset", {code, busy, done, sat}, 0);
    last_chg = 0; gap_viol = 0; step_viol = 0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit && !done; i++) @(negedge clk);
  endtask

  task automatic run_search(input int t, input int exp_code, input bit exp_sat);
    do_reset();
    thr = t;
    pulse_start();
    check(busy && ref_en && cmp_en && !done && code == 0, "R2 start accepted", {busy, ref_en, cmp_en}, 7);
    repeat (20) @(negedge clk);
    check(code == 0 && !done, "R3 hold before ready", code, 0);
    ready = 1'b1;
    wait_done(2000);
    check(done, "R8 done reached", done, 1);
    check(code == exp_code, exp_sat ? "R7 saturated code" : "R6 final code", code, exp_code);
    check(sat == exp_sat, exp_sat ? "R7 sat flag" : "R6 sat clear", sat, exp_sat);
    check(!busy && !ref_en && !cmp_en, "R8 helpers off", {busy, ref_en, cmp_en}, 0);
    check(gap_viol == 0, "R4 settle spacing", gap_viol, 0);
    check(step_viol == 0, "R5 unit steps", step_viol, 0);
    pulse_start();
    repeat (40) @(negedge clk);
    check(done && !busy && code == exp_code, "R9 start ignored after done", code, exp_code);
    check(done && !busy, "R10 done sticky, busy low", {done, busy}, 2);
  endtask

  task automatic start_while_busy();
    do_reset();
    thr = 5;
    pulse_start();
    ready = 1'b1;
    for (int i = 0; i < 2000 && code != 3; i++) @(negedge clk);
    pulse_start();
    repeat (2) @(negedge clk);
    check(code == 3 && busy, "R9 start ignored while busy", code, 3);
    wait_done(2000);
    check(code == 6 && !sat, "R6 run continues after ignored start", code, 6);
  endtask

  task automatic settle_timing();
    int t0;
    do_reset();
    thr = 0;
    pulse_start();
    ready = 1'b1;
    t0 = cyc;
    wait_done(2000);
    check((cyc - t0) >= 2 * SETTLE, "R4 two settle windows", cyc - t0, 2 * SETTLE);
    check(code == 1, "R5 sync trip at code 1", code, 1);
  endtask

  initial begin
    run_search(-1, 0, 1'b0);
    run_search(2, 3, 1'b0);
    run_search(6, 7, 1'b0);
    run_search(7, 7, 1'b1);
    start_while_busy();
    settle_timing();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule